// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Emulator

This block behaves like a small serial EEPROM of 512 bytes on an SPI bus in mode 0. It samples chip select, serial clock and serial data input with the system clock. It returns data on a serial output that comes with its own output enable, so the pad's tri-state buffer sits outside the block. Every selection begins with one instruction byte, sent most significant bit first. The lower three bits of that byte pick one of six operations: set or clear the write-enable latch, read or write the status register, and read or write the array. For array access, bit 3 of the instruction byte is the ninth address bit. One address byte then follows.

Writes to the array and to the status register are two-step. A separate instruction must first set the write-enable latch. The write then takes effect only when chip select rises on a byte boundary. Array bytes are collected in a 16-byte page buffer whose offset wraps inside the page. A commit clears the latch and starts a busy period of a parameterised number of clock cycles, and during that period only status reads are served. An undefined instruction byte silences the device until the next selection.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the output enable is low, the write-enable latch and write-in-progress flag are clear, and every array byte reads 0xFF.
- R2: Instruction xxxx_x110 with the upper nibble zero sets the write-enable latch when chip select rises. Bytes clocked in after it in the same selection have no effect.
- R3: Instruction 0000_x100 clears the write-enable latch when chip select rises.
- R4: Instruction 0000_x101 returns the status byte, MSB first, and repeats it for as long as clocks continue. The layout is bit 0 write-in-progress, bit 1 write-enable latch, bits 3:2 user flags, and the other bits zero.
- R5: Instruction 0000_A011 takes A as address bit 8 and the next byte as bits 7..0. Data bytes are then shifted out MSB first, with each bit changing after a falling clock edge. The address increments after each byte and wraps from 0x1FF to 0x000.
- R6: Instruction 0000_A010 with the latch set, followed by an address byte, buffers data bytes. The low 4 address bits increment and wrap inside the 16-byte page. The buffered bytes are written to the array when chip select rises.
- R7: A write-array or write-status instruction with the latch clear changes neither the array, the status register nor the busy flag.
- R8: If chip select rises in the middle of a data byte, the write is dropped and the write-enable latch keeps its value.
- R9: A committed write clears the latch and holds write-in-progress high for BUSY_CYCLES clock cycles, after which it clears by itself.
- R10: While write-in-progress is high, every instruction except status read is ignored, and its output stays disabled.
- R11: An instruction byte with a nonzero upper nibble, or with lower bits 000 or 111, disables the output. All further bits are ignored until the next selection.
- R12: The output enable is low whenever chip select is high, and during instructions that return no data.
- R13: Instruction 0000_x001 with the latch set writes bits 3:2 of the last whole data byte into the status user flags when chip select rises, and starts a busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data into the device |
| so_data | output | 1 | Serial data out of the device |
| so_en | output | 1 | Output enable for the external tri-state pad |

## Verification
The bench goes after the wrap points. A read that starts at 0x1FE must continue at 0x000, and a design that carried the ninth bit wrong would return upper-half data twice. A write at 0x1FE with three bytes must land its third byte at 0x1F0; a design that ignored the page boundary would write 0x000 instead. A deselect three bits into a data byte must leave the array and the latch untouched. A design that committed partial writes would show a changed byte and a cleared latch. During the busy period a write-enable and an array read are sent; a design that still decoded them would report the latch set afterwards or drive the output. An undefined opcode followed by a valid write-enable in the same selection must leave the latch clear.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int EE_ADDR_W = 9;
    localparam int EE_BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_RSTAT,
        PH_WSTAT,
        PH_HOLD,
        PH_DEAD
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WREN,
        OP_WRDI,
        OP_RDSR,
        OP_WRSR,
        OP_READ,
        OP_WRITE,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic active;
        logic sel_end;
        logic sck_rise;
        logic sck_fall;
        logic din;
    } bus_ev_t;

    function automatic op_e decode_op(input logic [7:0] b);
        op_e r;
        if (b[7:4] != 4'b0000) begin
            r = OP_BAD;
        end else begin
            case (b[2:0])
                3'b110:  r = OP_WREN;
                3'b100:  r = OP_WRDI;
                3'b101:  r = OP_RDSR;
                3'b001:  r = OP_WRSR;
                3'b011:  r = OP_READ;
                3'b010:  r = OP_WRITE;
                default: r = OP_BAD;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ee_spi_sync.sv
module ee_spi_sync
    import eeprom_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sclk,
    input  logic    mosi,
    output bus_ev_t ev
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] din_pipe;
    logic              cs_d;
    logic              sck_d;
    logic              cs_s;
    logic              sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_pipe  <= '1;
            sck_pipe <= '0;
            din_pipe <= '0;
            cs_d     <= 1'b1;
            sck_d    <= 1'b0;
        end else begin
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
            sck_pipe <= {sck_pipe[STAGES-2:0], sclk};
            din_pipe <= {din_pipe[STAGES-2:0], mosi};
            cs_d     <= cs_s;
            sck_d    <= sck_s;
        end
    end

    assign cs_s  = cs_pipe[STAGES-1];
    assign sck_s = sck_pipe[STAGES-1];

    always_comb begin
        ev.active   = !cs_s;
        ev.sel_end  = !cs_d && cs_s;
        ev.sck_rise = !sck_d && sck_s;
        ev.sck_fall = sck_d && !sck_s;
        ev.din      = din_pipe[STAGES-1];
    end

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        wr,
    input  logic [PAGE_W-1:0]           idx,
    input  logic [7:0]                  wdata,
    output logic [(1<<PAGE_W)-1:0]      valid,
    output logic [(1<<PAGE_W)-1:0][7:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            data  <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr) begin
            data[idx]  <= wdata;
            valid[idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/ee_array.sv
module ee_array
    import eeprom_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            commit,
    input  logic [EE_ADDR_W-PAGE_W-1:0]     page_base,
    input  logic [(1<<PAGE_W)-1:0]          pg_valid,
    input  logic [(1<<PAGE_W)-1:0][7:0]     pg_data,
    input  logic [EE_ADDR_W-1:0]            rd_addr,
    output logic [7:0]                      rd_data
);
    localparam int DEPTH    = 1 << EE_ADDR_W;
    localparam int PAGE_LEN = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_LEN; i++) begin
                if (pg_valid[i]) begin
                    mem[{page_base, PAGE_W'(i)}] <= pg_data[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ee_cmd_fsm.sv
module ee_cmd_fsm
    import eeprom_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  bus_ev_t                     ev,
    input  logic                        wel,
    input  logic                        busy,
    input  logic [7:0]                  status_byte,
    input  logic [7:0]                  rd_data,
    output logic [EE_ADDR_W-1:0]        rd_addr,
    output logic                        so_data,
    output logic                        so_en,
    output logic                        wel_set,
    output logic                        wel_clr,
    output logic                        stat_wr,
    output logic [1:0]                  stat_val,
    output logic                        buf_clr,
    output logic                        buf_wr,
    output logic [PAGE_W-1:0]           buf_idx,
    output logic [7:0]                  buf_data,
    output logic                        commit,
    output logic [EE_ADDR_W-PAGE_W-1:0] page_base
);
    phase_e               phase;
    op_e                  pend;
    op_e                  cmd_op;
    logic [2:0]           bit_cnt;
    logic [6:0]           sh_in;
    logic [7:0]           nb;
    logic                 a8;
    logic                 rd_mode;
    logic                 got_byte;
    logic [EE_ADDR_W-1:0] addr;
    logic [PAGE_W-1:0]    wr_off;
    logic [1:0]           sr_val;
    logic [7:0]           out_sh;
    logic [2:0]           out_cnt;
    logic                 so_q;
    logic                 shifting;
    logic                 out_phase;
    logic                 byte_done;
    logic                 end_ok;
    logic [7:0]           load_byte;

    assign nb        = {sh_in, ev.din};
    assign cmd_op    = decode_op(nb);
    assign shifting  = (phase == PH_CMD) || (phase == PH_ADDR) ||
                       (phase == PH_WDATA) || (phase == PH_WSTAT);
    assign out_phase = (phase == PH_RDATA) || (phase == PH_RSTAT);
    assign byte_done = ev.active && ev.sck_rise && shifting && (bit_cnt == 3'd7);
    assign end_ok    = ev.sel_end && (bit_cnt == 3'd0) && got_byte;
    assign load_byte = (phase == PH_RDATA) ? rd_data : status_byte;

    assign wel_set   = ev.sel_end && (phase == PH_HOLD) && (pend == OP_WREN);
    assign wel_clr   = ev.sel_end && (phase == PH_HOLD) && (pend == OP_WRDI);
    assign stat_wr   = end_ok && (phase == PH_WSTAT);
    assign commit    = end_ok && (phase == PH_WDATA);
    assign buf_clr   = byte_done && (phase == PH_ADDR) && !rd_mode;
    assign buf_wr    = byte_done && (phase == PH_WDATA);
    assign buf_idx   = wr_off;
    assign buf_data  = nb;
    assign stat_val  = sr_val;
    assign page_base = addr[EE_ADDR_W-1:PAGE_W];
    assign rd_addr   = addr;
    assign so_data   = so_q;
    assign so_en     = ev.active && out_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            pend     <= OP_NONE;
            bit_cnt  <= '0;
            sh_in    <= '0;
            a8       <= 1'b0;
            rd_mode  <= 1'b0;
            got_byte <= 1'b0;
            addr     <= '0;
            wr_off   <= '0;
            sr_val   <= '0;
            out_sh   <= '0;
            out_cnt  <= '0;
            so_q     <= 1'b0;
        end else if (!ev.active) begin
            phase    <= PH_CMD;
            pend     <= OP_NONE;
            bit_cnt  <= '0;
            got_byte <= 1'b0;
            out_cnt  <= '0;
        end else begin
            if (ev.sck_rise && shifting) begin
                sh_in   <= nb[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_CMD: begin
                            if (busy && cmd_op != OP_RDSR) begin
                                phase <= PH_DEAD;
                            end else begin
                                case (cmd_op)
                                    OP_WREN, OP_WRDI: begin
                                        phase <= PH_HOLD;
                                        pend  <= cmd_op;
                                    end
                                    OP_RDSR: phase <= PH_RSTAT;
                                    OP_WRSR: phase <= wel ? PH_WSTAT : PH_HOLD;
                                    OP_READ: begin
                                        phase   <= PH_ADDR;
                                        rd_mode <= 1'b1;
                                        a8      <= nb[3];
                                    end
                                    OP_WRITE: begin
                                        phase   <= wel ? PH_ADDR : PH_HOLD;
                                        rd_mode <= 1'b0;
                                        a8      <= nb[3];
                                    end
                                    default: phase <= PH_DEAD;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            addr   <= {a8, nb};
                            wr_off <= nb[PAGE_W-1:0];
                            phase  <= rd_mode ? PH_RDATA : PH_WDATA;
                        end
                        PH_WDATA: begin
                            wr_off   <= wr_off + 1'b1;
                            got_byte <= 1'b1;
                        end
                        PH_WSTAT: begin
                            sr_val   <= nb[3:2];
                            got_byte <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (ev.sck_fall && out_phase) begin
                out_cnt <= out_cnt + 3'd1;
                if (out_cnt == 3'd0) begin
                    so_q   <= load_byte[7];
                    out_sh <= {load_byte[6:0], 1'b0};
                    if (phase == PH_RDATA) begin
                        addr <= addr + 1'b1;
                    end
                end else begin
                    so_q   <= out_sh[7];
                    out_sh <= {out_sh[6:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
    import eeprom_pkg::*;
#(
    parameter int BUSY_CYCLES = 256,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic so_data,
    output logic so_en
);
    localparam int BUSY_W   = $clog2(BUSY_CYCLES + 1);
    localparam int PAGE_LEN = 1 << PAGE_W;
    localparam int PBASE_W  = EE_ADDR_W - PAGE_W;

    bus_ev_t                     bus_ev;
    logic                        wel_q;
    logic [1:0]                  flags_q;
    logic [BUSY_W-1:0]           busy_cnt;
    logic                        busy;
    logic [7:0]                  status_byte;
    logic [EE_ADDR_W-1:0]        rd_addr;
    logic [7:0]                  rd_data;
    logic                        wel_set;
    logic                        wel_clr;
    logic                        stat_wr_w;
    logic [1:0]                  stat_val;
    logic                        buf_clr;
    logic                        buf_wr;
    logic [PAGE_W-1:0]           buf_idx;
    logic [7:0]                  buf_data;
    logic                        commit_w;
    logic [PBASE_W-1:0]          page_base;
    logic [PAGE_LEN-1:0]         pg_valid;
    logic [PAGE_LEN-1:0][7:0]    pg_data;
    logic                        sel_end_w;

    ee_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .mosi (mosi),
        .ev   (bus_ev)
    );

    ee_cmd_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (bus_ev),
        .wel         (wel_q),
        .busy        (busy),
        .status_byte (status_byte),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .so_data     (so_data),
        .so_en       (so_en),
        .wel_set     (wel_set),
        .wel_clr     (wel_clr),
        .stat_wr     (stat_wr_w),
        .stat_val    (stat_val),
        .buf_clr     (buf_clr),
        .buf_wr      (buf_wr),
        .buf_idx     (buf_idx),
        .buf_data    (buf_data),
        .commit      (commit_w),
        .page_base   (page_base)
    );

    ee_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk   (clk),
        .rst   (rst),
        .clr   (buf_clr),
        .wr    (buf_wr),
        .idx   (buf_idx),
        .wdata (buf_data),
        .valid (pg_valid),
        .data  (pg_data)
    );

    ee_array #(.PAGE_W(PAGE_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit_w),
        .page_base (page_base),
        .pg_valid  (pg_valid),
        .pg_data   (pg_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q    <= 1'b0;
            flags_q  <= '0;
            busy_cnt <= '0;
        end else begin
            if (commit_w || stat_wr_w) begin
                wel_q    <= 1'b0;
                busy_cnt <= BUSY_W'(BUSY_CYCLES);
            end else begin
                if (wel_set) wel_q <= 1'b1;
                else if (wel_clr) wel_q <= 1'b0;
                if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            end
            if (stat_wr_w) flags_q <= stat_val;
        end
    end

    assign busy        = (busy_cnt != '0);
    assign status_byte = {4'b0000, flags_q, wel_q, busy};
    assign sel_end_w   = bus_ev.sel_end;

endmodule

// File: rtl/ee_checker.sv
module ee_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic so_en,
    input logic wel,
    input logic busy,
    input logic sel_end,
    input logic commit,
    input logic stat_wr
);
    // R2: latch may only become set on the cycle after a deselect event
    p_wel_set_on_deselect_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(sel_end));

    // R3: latch may only clear on the cycle after a deselect event
    p_wel_clr_on_deselect_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(wel) |-> $past(sel_end));

    // R9: a busy period never starts with the latch still set
    p_busy_start_clears_wel_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !wel);

    // R10: no array or status commit while a busy period runs
    p_no_commit_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(commit || stat_wr));

    // R12: output released once chip select has been high for three samples
    p_quiet_deselected_r12: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_en);

endmodule

bind eeprom_spi_slave ee_checker u_ee_checker (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .so_en   (so_en),
    .wel     (wel_q),
    .busy    (busy),
    .sel_end (sel_end_w),
    .commit  (commit_w),
    .stat_wr (stat_wr_w)
);

// File: tb/eeprom_spi_slave_bench.sv
module eeprom_spi_slave_bench;

    localparam int HALF     = 6;
    localparam int BUSY     = 900;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic so_data;
    logic so_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] ref_mem [512];
    bit         ref_wel = 0;
    bit         ref_busy = 0;
    logic [1:0] ref_flags = 2'b00;

    bit oe_forbid = 0;
    bit oe_err_seen = 0;
    int cs_high_cnt = 0;

    always #4 clk = ~clk;

    eeprom_spi_slave #(.BUSY_CYCLES(BUSY)) u_eeprom_spi_slave (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .so_data (so_data),
        .so_en   (so_en)
    );

    // per-clock model of when the output may be enabled (R12, R10, R11)
    always @(negedge clk) begin
        if (rst) cs_high_cnt <= 0;
        else if (cs_n) cs_high_cnt <= cs_high_cnt + 1;
        else cs_high_cnt <= 0;
        if (!rst && so_en && (oe_forbid || cs_high_cnt > 4) && !oe_err_seen) begin
            oe_err_seen = 1;
            $display("FAIL R12: so_en actual 1 expected 0 at time %0t", $time);
        end
    end

    function automatic logic [7:0] ref_status();
        return {4'b0000, ref_flags, ref_wel, ref_busy};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        cyc(HALF);
    endtask

    task automatic desel();
        cyc(HALF);
        cs_n = 1'b1;
        cyc(8);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nbits,
                         output logic [7:0] rx, output bit en_all);
        rx = 8'h00;
        en_all = 1;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            cyc(HALF);
            rx[i] = so_data;
            if (!so_en) en_all = 0;
            sclk = 1'b1;
            cyc(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit en_all);
        xbits(tx, 8, rx, en_all);
    endtask

    task automatic simple_cmd(input logic [7:0] op);
        logic [7:0] rx;
        bit en;
        oe_forbid = 1;
        sel();
        xfer(op, rx, en);
        desel();
        oe_forbid = 0;
    endtask

    task automatic rd_status(input string req, input int n);
        logic [7:0] rx;
        bit en;
        sel();
        xfer(8'h05, rx, en);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, en);
            chk(req, rx, ref_status());
        end
        desel();
    endtask

    task automatic rd_array(input string req, input logic [8:0] a, input int n);
        logic [7:0] rx;
        bit en;
        sel();
        xfer({4'b0000, a[8], 3'b011}, rx, en);
        xfer(a[7:0], rx, en);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, en);
            chk(req, rx, ref_mem[(int'(a) + k) % 512]);
            chk({req, " oe"}, {7'b0, en}, 8'h01);
        end
        desel();
    endtask

    task automatic wr_array(input logic [8:0] a, input logic [7:0] d [$], input int extra_bits);
        logic [7:0] rx;
        bit en;
        bit take;
        oe_forbid = 1;
        sel();
        xfer({4'b0000, a[8], 3'b010}, rx, en);
        xfer(a[7:0], rx, en);
        foreach (d[k]) xfer(d[k], rx, en);
        if (extra_bits > 0) xbits(8'h55, extra_bits, rx, en);
        desel();
        oe_forbid = 0;
        take = ref_wel && !ref_busy && d.size() > 0 && extra_bits == 0;
        if (take) begin
            foreach (d[k]) ref_mem[{a[8:4], 4'(a[3:0] + k)}] = d[k];
            ref_wel = 0;
            ref_busy = 1;
        end
    endtask

    task automatic wr_status(input logic [7:0] v);
        logic [7:0] rx;
        bit en;
        oe_forbid = 1;
        sel();
        xfer(8'h01, rx, en);
        xfer(v, rx, en);
        desel();
        oe_forbid = 0;
        if (ref_wel && !ref_busy) begin
            ref_flags = v[3:2];
            ref_wel = 0;
            ref_busy = 1;
        end
    endtask

    task automatic wait_idle();
        cyc(BUSY + 20);
        ref_busy = 0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        logic [7:0] rx;
        bit en;
        logic [7:0] q [$];
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
        cyc(5);
        rst = 1'b0;
        cyc(3);

        // R1: output disabled after reset
        chk("R1 oe after reset", {7'b0, so_en}, 8'h00);
        // R1 R4: status clear and repeated
        rd_status("R4 status after reset", 2);
        rd_array("R1 array reset value", 9'h0A0, 2);

        // R2: WREN, trailing byte in the same selection ignored
        oe_forbid = 1;
        sel();
        xfer(8'h06, rx, en);
        xfer(8'h04, rx, en);
        desel();
        oe_forbid = 0;
        ref_wel = 1;
        rd_status("R2 latch set", 1);
        // R2: don't-care bit 3 form
        simple_cmd(8'h0C);
        ref_wel = 0;
        rd_status("R3 latch cleared", 1);
        simple_cmd(8'h0E);
        ref_wel = 1;
        rd_status("R2 latch set via 0E", 1);
        simple_cmd(8'h04);
        ref_wel = 0;
        rd_status("R3 latch cleared via 04", 1);

        // R7: writes without latch
        q = '{8'h11, 8'h22};
        wr_array(9'h010, q, 0);
        rd_array("R7 array unchanged", 9'h010, 2);
        wr_status(8'h0C);
        rd_status("R7 status unchanged", 1);

        // R6 R9: lower page then upper page with wrap
        simple_cmd(8'h06);
        ref_wel = 1;
        q = '{8'h5A};
        wr_array(9'h000, q, 0);
        rd_status("R9 busy and latch cleared", 1);
        wait_idle();
        rd_status("R9 busy expired", 1);

        simple_cmd(8'h06);
        ref_wel = 1;
        q = '{8'hA1, 8'hA2, 8'hA3};
        wr_array(9'h1FE, q, 0);
        wait_idle();
        rd_array("R5 read wrap 1FF to 000", 9'h1FE, 4);
        rd_array("R6 page wrap to 1F0", 9'h1F0, 1);
        rd_array("R5 address bit 8 lower half", 9'h0FE, 2);

        // R8: partial byte at deselect
        simple_cmd(8'h06);
        ref_wel = 1;
        q = '{8'h77};
        wr_array(9'h020, q, 3);
        rd_status("R8 latch kept after abort", 1);
        rd_array("R8 array unchanged after abort", 9'h020, 1);

        // R13: status write with latch still set
        wr_status(8'h0C);
        rd_status("R13 status during busy", 3);
        wait_idle();
        rd_status("R13 user flags written", 1);

        // R10: instructions during busy
        simple_cmd(8'h06);
        ref_wel = 1;
        q = '{8'hC3};
        wr_array(9'h040, q, 0);
        simple_cmd(8'h06);
        oe_forbid = 1;
        sel();
        xfer(8'h03, rx, en);
        xfer(8'h40, rx, en);
        xfer(8'h00, rx, en);
        desel();
        oe_forbid = 0;
        rd_status("R10 status served while busy", 1);
        wait_idle();
        rd_status("R10 WREN ignored while busy", 1);
        rd_array("R10 committed data", 9'h040, 1);

        // R11: undefined opcodes
        oe_forbid = 1;
        sel();
        xfer(8'hA6, rx, en);
        xfer(8'h06, rx, en);
        xfer(8'h05, rx, en);
        desel();
        sel();
        xfer(8'h07, rx, en);
        xfer(8'h06, rx, en);
        desel();
        oe_forbid = 0;
        rd_status("R11 no effect after bad opcode", 1);
        simple_cmd(8'h06);
        ref_wel = 1;
        rd_status("R11 next selection decoded", 1);

        // R12: per-clock output enable monitor
        chk("R12 oe monitor", {7'b0, oe_err_seen}, 8'h00);

        finished = 1;
        summary();
    end

    initial begin
        cyc(WATCHDOG);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule